// File: doc/BRIEF.md
# Windowed RMS Power Meter

This block measures the power of a stream of signed samples over a window whose length is set in samples. It squares each accepted sample and keeps only the top bits of the square as a fixed-point power term. It sums those terms in a saturating accumulator. When a window closes, it writes one of two results into a holding register and pulses a valid strobe: either the formatted mean-square sum or its integer square root.

Window framing uses a reloadable down-counter that fires at a count of one. The sample that arrives when the counter reads one does two things: it closes the running window, and it becomes the first term of the next window. The accumulator is loaded with that sample's power instead of being cleared. At the window end the accumulator is captured into a snapshot. A bit-serial square root then works on the snapshot while the next window keeps accumulating. A gain-control loop or a host can read the result after each strobe.

Top module: `pwr_rms_meter`

## Requirements
- R1: The power term of a sample is floor(m*m / 8192), where m is the sample's magnitude. This equals bits 23..13 of the 24-bit square, giving an 11-bit term. The sign of the sample has no effect on it.
- R2: The window length P is taken from `period_i` whenever a window starts. Values 1 to 127 are raised to 128, and 0 means 2^24.
- R3: Once enabled, the first accepted sample opens window 0. Window k then holds accepted samples k*P through k*P+P-1. The sample that closes window k is sample k*P+P, and it is the first term of window k+1.
- R4: The accumulator saturates at 0xFFFFFF instead of wrapping.
- R5: `mode_i` = 0 selects mean-square output, which is bits 23..4 of the accumulated sum. `mode_i` = 1 selects the floor of the square root of the 24-bit sum, as a 12-bit root zero-extended to 20 bits. The mode is sampled one cycle after the closing sample.
- R6: `result_valid_o` is high for exactly one cycle each time `result_o` is written. `result_o` does not change at any other time.
- R7: While `en_i` is low, samples are ignored, no result is produced and `result_o` holds its value. After `en_i` returns high, the next accepted sample opens a fresh window, and any partial sum is discarded.
- R8: A square-root result appears no more than 20 cycles after the closing sample, which is well before the next window can close.
- R9: After reset, `result_o` is 0 and `result_valid_o` is 0.
- R10: Cycles with `sample_valid_i` low neither count toward the window nor add power.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low halts and re-arms the window |
| sample_valid_i | input | 1 | Sample strobe |
| sample_i | input | 12 | Signed two's-complement sample |
| period_i | input | 24 | Window length in samples |
| mode_i | input | 1 | 0 mean-square, 1 root-mean-square |
| result_o | output | 20 | Result holding register |
| result_valid_o | output | 1 | One-cycle pulse when result_o is written |

## Verification
The assertions rely on the window lasting far longer than the square root. They check that no new root starts while one is running and that the root is checked against an operand that stays stable until the next window end. Both properties depend on every window being at least 128 samples long. The bench never asks for less: a period of 5 is clamped by the design itself. The bench also holds `mode_i` and `period_i` constant while a stream runs, and changes them only while the block is disabled.

// File: rtl/pwr_meter_pkg.sv
package pwr_meter_pkg;
  typedef enum logic {
    MODE_MS  = 1'b0,
    MODE_RMS = 1'b1
  } pwr_mode_e;
endpackage

// File: rtl/pwr_term.sv
module pwr_term #(
  parameter int unsigned SAMPLE_W = 12,
  parameter int unsigned TERM_W   = 11
) (
  input  logic signed [SAMPLE_W-1:0] sample_i,
  output logic        [TERM_W-1:0]   term_o
);
  localparam int unsigned SQ_W = 2 * SAMPLE_W;

  logic [SAMPLE_W-1:0] mag;
  logic [SQ_W-1:0]     sq;

  // magnitude of the most negative code still fits unsigned
  always_comb begin
    mag    = sample_i[SAMPLE_W-1] ? (~sample_i + 1'b1) : sample_i;
    sq     = SQ_W'(mag) * SQ_W'(mag);
    term_o = TERM_W'(sq >> (SQ_W - TERM_W));
  end
endmodule

// File: rtl/pwr_window.sv
module pwr_window #(
  parameter int unsigned PERIOD_W   = 24,
  parameter int unsigned ACC_W      = 24,
  parameter int unsigned TERM_W     = 11,
  parameter int unsigned MIN_PERIOD = 128
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                valid_i,
  input  logic [TERM_W-1:0]   term_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                close_o,
  output logic [ACC_W-1:0]    snap_o
);
  localparam int unsigned TMR_W = PERIOD_W + 1;

  logic             armed_q;
  logic [TMR_W-1:0] timer_q;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] snap_q;
  logic             close_q;

  logic [TMR_W-1:0] eff_period;
  logic [ACC_W:0]   acc_sum;
  logic [ACC_W-1:0] acc_next;
  logic [ACC_W-1:0] term_ext;

  always_comb begin
    if (period_i == '0)
      eff_period = TMR_W'(1) << PERIOD_W;
    else if (period_i < PERIOD_W'(MIN_PERIOD))
      eff_period = TMR_W'(MIN_PERIOD);
    else
      eff_period = {1'b0, period_i};
  end

  always_comb begin
    term_ext = ACC_W'(term_i);
    acc_sum  = {1'b0, acc_q} + {1'b0, term_ext};
    acc_next = acc_sum[ACC_W] ? '1 : acc_sum[ACC_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      timer_q <= '0;
      acc_q   <= '0;
      snap_q  <= '0;
      close_q <= 1'b0;
    end else begin
      close_q <= 1'b0;
      if (!en_i) begin
        armed_q <= 1'b0;
      end else if (valid_i) begin
        if (!armed_q) begin
          armed_q <= 1'b1;
          timer_q <= eff_period;
          acc_q   <= term_ext;
        end else if (timer_q == TMR_W'(1)) begin
          // boundary sample opens the next window
          snap_q  <= acc_q;
          close_q <= 1'b1;
          timer_q <= eff_period;
          acc_q   <= term_ext;
        end else begin
          timer_q <= timer_q - 1'b1;
          acc_q   <= acc_next;
        end
      end
    end
  end

  assign close_o = close_q;
  assign snap_o  = snap_q;

  a_r2_timer_bounds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> (timer_q >= TMR_W'(1) && timer_q <= (TMR_W'(1) << PERIOD_W)));

  a_r4_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && valid_i && armed_q && timer_q != TMR_W'(1)) |=> (acc_q >= $past(acc_q)));

  a_r7_halt_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(acc_q) && $stable(timer_q) && !close_o));
endmodule

// File: rtl/pwr_isqrt.sv
module pwr_isqrt #(
  parameter int unsigned RAD_W  = 24,
  parameter int unsigned ROOT_W = RAD_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [RAD_W-1:0]  rad_i,
  output logic              done_o,
  output logic [ROOT_W-1:0] root_o
);
  localparam int unsigned REM_W = ROOT_W + 2;
  localparam int unsigned CNT_W = $clog2(ROOT_W + 1);
  localparam int unsigned SQ_W  = 2 * ROOT_W + 2;

  logic [RAD_W-1:0]  rad_q;
  logic [REM_W-1:0]  rem_q;
  logic [ROOT_W-1:0] root_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q;
  logic              done_q;

  logic [REM_W-1:0] rem_sh;
  logic [REM_W-1:0] trial;
  logic             ge;

  // restoring step: two radicand bits in, one root bit out
  always_comb begin
    rem_sh = (rem_q << 2) | REM_W'(rad_q[RAD_W-1 -: 2]);
    trial  = {root_q, 2'b01};
    ge     = (rem_sh >= trial);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rad_q  <= '0;
      rem_q  <= '0;
      root_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        rad_q  <= rad_i;
        rem_q  <= '0;
        root_q <= '0;
        cnt_q  <= CNT_W'(ROOT_W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rad_q  <= rad_q << 2;
        rem_q  <= ge ? (rem_sh - trial) : rem_sh;
        root_q <= {root_q[ROOT_W-2:0], ge};
        cnt_q  <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign root_o = root_q;

  a_r8_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);

  a_r5_root_exact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> ((SQ_W'(root_q) * SQ_W'(root_q) <= SQ_W'(rad_i)) &&
                ((SQ_W'(root_q) + 1'b1) * (SQ_W'(root_q) + 1'b1) > SQ_W'(rad_i))));
endmodule

// File: rtl/pwr_rms_meter.sv
module pwr_rms_meter
  import pwr_meter_pkg::*;
#(
  parameter int unsigned SAMPLE_W   = 12,
  parameter int unsigned PERIOD_W   = 24,
  parameter int unsigned ACC_W      = 24,
  parameter int unsigned TERM_W     = 11,
  parameter int unsigned RES_W      = 20,
  parameter int unsigned MIN_PERIOD = 128
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       en_i,
  input  logic                       sample_valid_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic [PERIOD_W-1:0]        period_i,
  input  logic                       mode_i,
  output logic [RES_W-1:0]           result_o,
  output logic                       result_valid_o
);
  localparam int unsigned ROOT_W = ACC_W / 2;

  logic [TERM_W-1:0] term;
  logic              close;
  logic [ACC_W-1:0]  snap;
  logic              sqrt_start;
  logic              sqrt_done;
  logic [ROOT_W-1:0] root;
  logic [RES_W-1:0]  ms_fmt;
  logic [RES_W-1:0]  result_q;
  logic              valid_q;

  pwr_term #(
    .SAMPLE_W(SAMPLE_W),
    .TERM_W  (TERM_W)
  ) u_term (
    .sample_i(sample_i),
    .term_o  (term)
  );

  pwr_window #(
    .PERIOD_W  (PERIOD_W),
    .ACC_W     (ACC_W),
    .TERM_W    (TERM_W),
    .MIN_PERIOD(MIN_PERIOD)
  ) u_window (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .valid_i (sample_valid_i),
    .term_i  (term),
    .period_i(period_i),
    .close_o (close),
    .snap_o  (snap)
  );

  assign sqrt_start = close && (pwr_mode_e'(mode_i) == MODE_RMS);

  pwr_isqrt #(
    .RAD_W (ACC_W),
    .ROOT_W(ROOT_W)
  ) u_isqrt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(sqrt_start),
    .rad_i  (snap),
    .done_o (sqrt_done),
    .root_o (root)
  );

  // keep the top bits of the sum when the result is narrower
  generate
    if (RES_W >= ACC_W) begin : g_ms_wide
      assign ms_fmt = RES_W'(snap);
    end else begin : g_ms_narrow
      assign ms_fmt = RES_W'(snap >> (ACC_W - RES_W));
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (close && (pwr_mode_e'(mode_i) == MODE_MS)) begin
        result_q <= ms_fmt;
        valid_q  <= 1'b1;
      end else if (sqrt_done) begin
        result_q <= RES_W'(root);
        valid_q  <= 1'b1;
      end
    end
  end

  assign result_o       = result_q;
  assign result_valid_o = valid_q;

  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |=> !result_valid_o);

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !result_valid_o |-> (result_o == $past(result_o)));

  a_r7_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !$past(en_i)) |=> !close);
endmodule

// File: tb/tb_pwr_rms_meter.sv
module tb_pwr_rms_meter;
  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               en_i = 1'b0;
  logic               sample_valid_i = 1'b0;
  logic signed [11:0] sample_i = '0;
  logic [23:0]        period_i = 24'd128;
  logic               mode_i = 1'b0;
  logic [19:0]        result_o;
  logic               result_valid_o;

  int checks = 0;
  int errors = 0;
  longint cyc_cnt = 0;
  longint close_cyc = 0;

  pwr_rms_meter dut (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_i          (en_i),
    .sample_valid_i(sample_valid_i),
    .sample_i      (sample_i),
    .period_i      (period_i),
    .mode_i        (mode_i),
    .result_o      (result_o),
    .result_valid_o(result_valid_o)
  );

  always #10 clk_i = ~clk_i;
  always @(posedge clk_i) cyc_cnt <= cyc_cnt + 1;

  function automatic longint term_of(input longint s);
    longint m;
    m = (s < 0) ? -s : s;
    return (m * m) >> 13;
  endfunction

  function automatic longint isqrt_of(input longint x);
    longint r;
    r = 0;
    while ((r + 1) * (r + 1) <= x) r++;
    return r;
  endfunction

  function automatic int pat(input int kind, input int amp, input int idx);
    if (kind == 0) return amp;
    return ((idx * 37 + amp) % 4096) - 2048;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic restart();
    @(negedge clk_i);
    en_i = 1'b0;
    sample_valid_i = 1'b0;
    repeat (2) @(negedge clk_i);
    en_i = 1'b1;
  endtask

  // drive nwin*eff+1 samples and compare every window result
  task automatic run_stream(input string req, input int per_in, input int eff,
                            input int nwin, input int kind, input int amp,
                            input bit gaps, input bit rms, input bit fresh);
    longint expv [8];
    longint sum;
    int     got;
    if (fresh) begin
      @(negedge clk_i);
      en_i = 1'b0;
      period_i = 24'(per_in);
      mode_i = rms;
      restart();
    end else begin
      period_i = 24'(per_in);
      mode_i = rms;
    end
    for (int w = 0; w < nwin; w++) begin
      sum = 0;
      for (int j = 0; j < eff; j++) sum += term_of(longint'(pat(kind, amp, w * eff + j)));
      if (sum > 64'hFFFFFF) sum = 64'hFFFFFF;
      expv[w] = rms ? isqrt_of(sum) : (sum >> 4);
    end
    got = 0;
    fork
      begin
        for (int i = 0; i <= nwin * eff; i++) begin
          if (gaps && (i % 3 == 1)) begin
            @(negedge clk_i);
            sample_valid_i = 1'b0;
            sample_i = 12'sd2047;
          end
          @(negedge clk_i);
          sample_valid_i = 1'b1;
          sample_i = 12'(pat(kind, amp, i));
          if (i % eff == 0 && i != 0) close_cyc = cyc_cnt;
        end
        @(negedge clk_i);
        sample_valid_i = 1'b0;
      end
      begin
        for (int c = 0; c < nwin * eff * 2 + 200 && got < nwin; c++) begin
          @(negedge clk_i);
          if (result_valid_o) begin
            check({req, " window value"}, longint'(result_o), expv[got]);
            if (rms) check("R8 root latency within 20", (cyc_cnt - close_cyc <= 20) ? 1 : 0, 1);
            got++;
            @(negedge clk_i);
            check("R6 one-cycle valid", longint'(result_valid_o), 0);
          end
        end
        check({req, " result count"}, got, nwin);
      end
    join
  endtask

  task automatic t_reset();
    check("R9 reset result", longint'(result_o), 0);
    check("R9 reset valid", longint'(result_valid_o), 0);
  endtask

  task automatic t_enable_halt();
    logic [19:0] held;
    int pulses;
    held = result_o;
    pulses = 0;
    period_i = 24'd128;
    mode_i = 1'b0;
    restart();
    for (int i = 0; i < 50; i++) begin
      @(negedge clk_i);
      sample_valid_i = 1'b1;
      sample_i = 12'sd2000;
    end
    @(negedge clk_i);
    en_i = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk_i);
      sample_valid_i = 1'b1;
      sample_i = -12'sd2047;
      if (result_valid_o) pulses++;
    end
    sample_valid_i = 1'b0;
    check("R7 no result while disabled", pulses, 0);
    check("R7 result held while disabled", longint'(result_o), longint'(held));
    @(negedge clk_i);
    en_i = 1'b1;
    // fresh window must exclude the partial 2000-valued samples
    run_stream("R7 fresh window after re-enable", 128, 128, 1, 0, 1000, 0, 0, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    run_stream("R1 R5 ms constant", 128, 128, 2, 0, 1000, 0, 0, 1);
    run_stream("R5 rms constant", 128, 128, 2, 0, 1000, 0, 1, 1);
    run_stream("R1 negative rms", 128, 128, 1, 0, -1000, 0, 1, 1);
    run_stream("R1 truncation to zero", 128, 128, 1, 0, 90, 0, 0, 1);
    run_stream("R3 ramp ms", 200, 200, 3, 1, 5, 0, 0, 1);
    run_stream("R10 gaps rms", 150, 150, 2, 1, 300, 1, 1, 1);
    run_stream("R2 clamp to 128", 5, 128, 2, 1, 77, 0, 0, 1);
    t_enable_halt();
    run_stream("R4 saturate ms", 40000, 40000, 1, 0, -2048, 0, 0, 1);
    run_stream("R4 saturate rms", 40000, 40000, 1, 0, 2047, 0, 1, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule